// File: doc/BRIEF.md
# Gated Serial Clock Divider with Stop Handshake

This block derives the serial clock for a flash controller from the system clock. A prescaler splits the system clock by a power of two, producing one tick per half-period of the serial clock. Each tick toggles the serial clock level and raises either a shift strobe (launch outgoing data) or a sample strobe (capture incoming data). The transaction engine uses those strobes.

Software gates the serial clock with an enable bit. Clearing the enable asks for a stop. The block grants the stop only at the end of a full low half-period, so the output never carries a shortened pulse. Software then waits for the clock-stopped status, and for the idle status that mirrors the transaction engine's busy flag, before it reconfigures. The divide code, phase and edge settings are captured at the moment the clock starts. Changes applied while it runs have no effect until the next stop and start.

Top module: `sclk_gen`

## Requirements
- R1: While reset is applied, and after it is released, sclk_o, shift_stb_o and sample_stb_o are low and clk_stopped_o and idle_o are high.
- R2: The divide code sets the half-period N of sclk_o in system cycles: code 0 gives N=1, 1 gives N=2, 2 gives N=4 and 3 gives N=8. After a start, sclk_o is low for the first N cycles, then toggles every N cycles.
- R3: With code 0, exactly one strobe is high in every running cycle. Shift and sample alternate from one cycle to the next.
- R4: With samp_edge_i=0, shift_stb_o pulses in the last cycle of each high half-period (a falling transition) and the sample edge is the rising transition. With samp_edge_i=1 the two edges are swapped. The two strobes are never high together.
- R5: With phase_i=0 (180 degrees), sample_stb_o pulses in the last cycle of the half-period that ends at the sample edge. With phase_i=1 (90 degrees) and N≥2, it pulses instead N/2 cycles after that edge, in cycle N/2-1 of the following half-period, and never in the first half-period after a start. With N=1, phase_i has no effect.
- R6: After clk_en_i is cleared, the clock stops at the end of the first low half-period that completes. No strobe is raised in that cycle. sclk_o then stays low with no strobes.
- R7: clk_stopped_o rises the cycle after the stop is taken. It clears in the first cycle after clk_en_i is seen high while stopped.
- R8: div_code_i, phase_i and samp_edge_i are captured when the clock starts. Changes made while it runs do not alter the output until the next start.
- R9: idle_o is the inverse of eng_busy_i delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Serial clock enable; clearing it requests a stop |
| div_code_i | input | 2 | Divide code (half-period 1, 2, 4 or 8 cycles) |
| phase_i | input | 1 | Sample phase: 0 = 180 degrees, 1 = 90 degrees |
| samp_edge_i | input | 1 | Swaps the shift and sample edges |
| eng_busy_i | input | 1 | Transaction engine busy |
| shift_stb_o | output | 1 | Launch strobe for outgoing data |
| sample_stb_o | output | 1 | Capture strobe for incoming data |
| sclk_o | output | 1 | Serial clock level |
| clk_stopped_o | output | 1 | Serial clock is stopped |
| idle_o | output | 1 | Transaction engine is idle |

## Verification
The bench drops the enable while sclk_o is high. A design that stopped at once would leave a clipped high pulse, or would park with the clock high, instead of finishing the high half and the following low half. A 90-degree run with swapped edges checks that no sample strobe appears in the first low half-period after a start. A design without that guard would capture data before any sample edge had occurred. Divide code, phase and edge are all changed in the middle of a run. A design that latched them continuously would change its half-period on the fly. The restart that follows must then take up the new values.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  typedef enum logic {
    PH_180 = 1'b0,
    PH_90  = 1'b1
  } phase_e;

  typedef enum logic {
    EDGE_NORMAL = 1'b0,
    EDGE_SWAP   = 1'b1
  } edge_e;

endpackage

// File: rtl/sclk_gate_ctl.sv
module sclk_gate_ctl
  import sclk_gen_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] div_i,
  input  logic              phase_i,
  input  logic              swap_i,
  input  logic              sclk_i,
  input  logic              at_end_i,
  output logic              running_o,
  output logic              start_o,
  output logic              stop_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic [CNT_W-1:0]  half_m1_o,
  output logic              div1_o,
  output phase_e            phase_o,
  output edge_e             swap_o
);

  logic              run_q, run_d;
  logic [CODE_W-1:0] div_q, div_d;
  phase_e            ph_q, ph_d;
  edge_e             sw_q, sw_d;
  logic              start_c, stop_c;
  logic [CNT_W:0]    len_c;

  always_comb begin
    start_c = !run_q && en_i;
    stop_c  = run_q && !en_i && !sclk_i && at_end_i;
    run_d   = run_q;
    div_d   = div_q;
    ph_d    = ph_q;
    sw_d    = sw_q;
    if (start_c) begin
      run_d = 1'b1;
      div_d = div_i;
      ph_d  = phase_e'(phase_i);
      sw_d  = edge_e'(swap_i);
    end else if (stop_c) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= '0;
      ph_q  <= PH_180;
      sw_q  <= EDGE_NORMAL;
    end else begin
      run_q <= run_d;
      div_q <= div_d;
      ph_q  <= ph_d;
      sw_q  <= sw_d;
    end
  end

  assign len_c     = {{CNT_W{1'b0}}, 1'b1} << div_q;
  assign lim_o     = CNT_W'(len_c - 1'b1);
  assign half_m1_o = CNT_W'((len_c >> 1) - 1'b1);
  assign div1_o    = (div_q == '0);
  assign running_o = run_q;
  assign start_o   = start_c;
  assign stop_o    = stop_c;
  assign phase_o   = ph_q;
  assign swap_o    = sw_q;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(div_q) && $stable(ph_q) && $stable(sw_q))); // R8
  AST_STOP_AT_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(!sclk_i && at_end_i)); // R6

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_end_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end_c;

  always_comb begin
    at_end_c = (cnt_q == lim_i);
    cnt_d    = cnt_q;
    if (start_i)
      cnt_d = '0;
    else if (running_i)
      cnt_d = at_end_c ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign at_end_o = at_end_c;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running_i |-> (cnt_q <= lim_i)); // R2

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import sclk_gen_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             at_end_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] half_m1_i,
  input  logic             div1_i,
  input  phase_e           phase_i,
  input  edge_e            swap_i,
  output logic             sclk_o,
  output logic             shift_o,
  output logic             sample_o
);

  logic sclk_q, sclk_d;
  logic first_q, first_d;
  logic tick_c, launch_lvl, edge_samp_c, mid_samp_c;

  always_comb begin
    tick_c      = running_i && at_end_i && !stop_i;
    launch_lvl  = (swap_i == EDGE_NORMAL);
    edge_samp_c = tick_c && (sclk_q != launch_lvl);
    mid_samp_c  = running_i && !first_q && !div1_i &&
                  (cnt_i == half_m1_i) && (sclk_q == launch_lvl);
    sclk_d  = tick_c ? !sclk_q : sclk_q;
    first_d = start_i ? 1'b1 : (tick_c ? 1'b0 : first_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_d;
      first_q <= first_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign shift_o  = tick_c && (sclk_q == launch_lvl);
  assign sample_o = (phase_i == PH_90 && !div1_i) ? mid_samp_c : edge_samp_c;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_o && sample_o)); // R4
  AST_NO_STROBE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !running_i |-> (!shift_o && !sample_o)); // R6
  AST_SCLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_i && $past(!running_i)) |-> $stable(sclk_q)); // R6

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              phase_i,
  input  logic              samp_edge_i,
  input  logic              eng_busy_i,
  output logic              shift_stb_o,
  output logic              sample_stb_o,
  output logic              sclk_o,
  output logic              clk_stopped_o,
  output logic              idle_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             running, start, stop, at_end, div1;
  logic [CNT_W-1:0] cnt, lim, half_m1;
  phase_e           phase_q;
  edge_e            swap_q;
  logic             idle_q, idle_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sclk_gate_ctl #(.CODE_W(CODE_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_i      (clk_en_i),
    .div_i     (div_code_i),
    .phase_i   (phase_i),
    .swap_i    (samp_edge_i),
    .sclk_i    (sclk_o),
    .at_end_i  (at_end),
    .running_o (running),
    .start_o   (start),
    .stop_o    (stop),
    .lim_o     (lim),
    .half_m1_o (half_m1),
    .div1_o    (div1),
    .phase_o   (phase_q),
    .swap_o    (swap_q)
  );

  sclk_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .running_i (running),
    .start_i   (start),
    .lim_i     (lim),
    .cnt_o     (cnt),
    .at_end_o  (at_end)
  );

  sclk_edge_gen #(.CNT_W(CNT_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .running_i (running),
    .start_i   (start),
    .stop_i    (stop),
    .at_end_i  (at_end),
    .cnt_i     (cnt),
    .half_m1_i (half_m1),
    .div1_i    (div1),
    .phase_i   (phase_q),
    .swap_i    (swap_q),
    .sclk_o    (sclk_o),
    .shift_o   (shift_stb_o),
    .sample_o  (sample_stb_o)
  );

  always_comb idle_d = !eng_busy_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) idle_q <= 1'b1;
    else            idle_q <= idle_d;
  end

  assign idle_o        = idle_q;
  assign clk_stopped_o = !running;

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    clk_stopped_o |-> !sclk_o); // R6
  AST_IDLE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(eng_busy_i) |=> !idle_o); // R9

endmodule

// File: tb/tb_sclk_gen.sv
module tb_sclk_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, phase, swap, busy;
  logic [1:0] code;
  logic       shift_stb, sample_stb, sclk, stopped, idle;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #10 clk = !clk;

  sclk_gen dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .clk_en_i      (en),
    .div_code_i    (code),
    .phase_i       (phase),
    .samp_edge_i   (swap),
    .eng_busy_i    (busy),
    .shift_stb_o   (shift_stb),
    .sample_stb_o  (sample_stb),
    .sclk_o        (sclk),
    .clk_stopped_o (stopped),
    .idle_o        (idle)
  );

  // {code[1:0], phase, swap, half-period N[3:0]}
  localparam logic [7:0] VECS [0:5] = '{
    {2'd0, 1'b0, 1'b0, 4'd1},
    {2'd1, 1'b0, 1'b1, 4'd2},
    {2'd2, 1'b1, 1'b0, 4'd4},
    {2'd3, 1'b1, 1'b1, 4'd8},
    {2'd1, 1'b1, 1'b1, 4'd2},
    {2'd0, 1'b1, 1'b0, 4'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One start/run/stop sequence, called at a negedge with the clock stopped.
  task automatic run_vec(input logic [1:0] c, input bit ph, input bit sw,
                         input int n, input bit mutate);
    int e_stop = 5 * n - 1;
    chk("R7", "stopped before start", int'(stopped), 1);
    code = c; phase = ph; swap = sw; en = 1'b1;
    @(negedge clk);
    for (int e = 0; e <= 5 * n + 2; e++) begin
      int  cnt = e % n;
      int  h   = e / n;
      bit  lvl = bit'(h % 2);
      bit  tick = (cnt == n - 1);
      bit  xs, xm;
      xs = tick && (lvl == !sw);
      if (ph && n > 1) xm = (cnt == n / 2 - 1) && (h >= 1) && (lvl == !sw);
      else             xm = tick && (lvl == sw);
      if (e < e_stop) begin
        chk("R2", "sclk level", int'(sclk), int'(lvl));
        chk((n == 1) ? "R3" : "R4", "shift strobe", int'(shift_stb), int'(xs));
        chk("R5", "sample strobe", int'(sample_stb), int'(xm));
        chk("R7", "stopped while running", int'(stopped), 0);
      end else if (e == e_stop) begin
        chk("R6", "sclk at stop", int'(sclk), 0);
        chk("R6", "strobes at stop", int'(shift_stb | sample_stb), 0);
        chk("R7", "stopped at stop cycle", int'(stopped), 0);
      end else begin
        chk("R6", "sclk after stop", int'(sclk), 0);
        chk("R6", "strobes after stop", int'(shift_stb | sample_stb), 0);
        chk("R7", "stopped after stop", int'(stopped), 1);
      end
      if (mutate && e == 1) begin   // R8: settings changed mid-run
        code = ~c; phase = !ph; swap = !sw;
      end
      if (e == 3 * n) en = 1'b0;    // request stop during a high half
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; code = '0; phase = 1'b0; swap = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sclk in reset", int'(sclk), 0);
    chk("R1", "strobes in reset", int'(shift_stb | sample_stb), 0);
    chk("R1", "stopped in reset", int'(stopped), 1);
    chk("R1", "idle in reset", int'(idle), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "sclk after reset", int'(sclk), 0);
    chk("R1", "stopped after reset", int'(stopped), 1);

    foreach (VECS[i]) begin
      run_vec(VECS[i][7:6], VECS[i][5], VECS[i][4], int'(VECS[i][3:0]), 1'b0);
    end

    // R8: mid-run changes ignored, then taken up on the next start
    run_vec(2'd1, 1'b0, 1'b0, 2, 1'b1);
    run_vec(2'd2, 1'b1, 1'b1, 4, 1'b0);

    // R9: idle follows busy with one cycle of delay
    busy = 1'b1;
    chk("R9", "idle same cycle", int'(idle), 1);
    @(negedge clk);
    chk("R9", "idle with busy", int'(idle), 0);
    busy = 1'b0;
    @(negedge clk);
    chk("R9", "idle after busy", int'(idle), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule